// File: doc/BRIEF.md
# Wakeup-Select Issue Scheduler

This block is a small out-of-order issue window. Dispatch writes one operation per cycle into any free slot. Each slot holds a destination tag and two source tags, and each source tag has a ready flag. Every cycle the block picks up to `ISSUE_W` ready operations, oldest first, and sends each one to a functional-unit lane. In the same cycle it broadcasts their destination tags so that waiting consumers can mark their operands ready.

Wakeup and select form a loop that closes within one clock. A consumer of a single-cycle producer can therefore issue in the cycle right after its producer. Multi-cycle producers (multiply, and loads assumed to hit the first-level cache) have their tag broadcast delayed by their latency minus one cycle. Their consumers then issue exactly that latency after the producer. A slot is released in the cycle after its grant. When every slot is occupied, `full_o` tells dispatch to stall.

Top module: `iq_sched`

## Requirements
- R1: A stored source becomes ready, and stays ready, once any broadcast carries its tag. An entry is eligible for issue only while both of its sources are ready. A source that never sees its tag keeps its entry from issuing.
- R2: Operations of class code 0 (single-cycle) broadcast their destination tag in their issue cycle. A consumer of such an operation issues in the next cycle, so a dependence chain advances one level per cycle.
- R3: Operations of class code 1 (multiply) broadcast `MUL_LAT`-1 cycles after issue. Their consumers issue exactly `MUL_LAT` cycles after the producer (3 by default).
- R4: Operations of class code 2 (load) are assumed to hit with latency `LOAD_HIT_LAT`. Their consumers issue exactly `LOAD_HIT_LAT` cycles after the producer (4 by default).
- R5: Class code 3 is timed as a single-cycle operation, so its consumers issue one cycle after it.
- R6: At most `ISSUE_W` entries issue per cycle, chosen oldest-first by insertion order. The oldest ready entry goes on lane 0 and the next oldest on lane 1. A lane is used only if every lower lane is used, and `issue_fu_o` of each lane equals its lane number.
- R7: An entry inserted in a cycle whose broadcast carries one of its source tags captures that wakeup.
- R8: A source flagged ready at insert needs no broadcast. An entry with both sources flagged ready issues in the cycle after insertion.
- R9: A granted entry frees its slot in the next cycle. `full_o` is high exactly while all `N_ENT` slots are occupied. An insert offered while `full_o` is high is dropped and never issues.
- R10: After reset the window is empty: `full_o` is low and no lane issues.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ins_valid_i | input | 1 | Insert request from dispatch |
| ins_dst_i | input | TAG_W | Destination tag of the inserted operation |
| ins_src_l_i | input | TAG_W | Left source tag |
| ins_rdy_l_i | input | 1 | Left source already available |
| ins_src_r_i | input | TAG_W | Right source tag |
| ins_rdy_r_i | input | 1 | Right source already available |
| ins_cls_i | input | 2 | Latency class: 0 single, 1 multiply, 2 load, 3 single |
| full_o | output | 1 | All slots occupied; dispatch must stall |
| issue_valid_o | output | ISSUE_W | Lane carries an issued operation |
| issue_tag_o | output | ISSUE_W x TAG_W | Destination tag per lane |
| issue_fu_o | output | ISSUE_W x FU_W | Functional-unit index per lane |

## Verification
The checker assumes that dispatch never relies on an insert accepted while `full_o` is high. It also assumes that a destination tag is not reused while an earlier holder of the tag is still in flight, so every broadcast has a single meaning. The stimulus resets between scenarios and gives every operation in a scenario a distinct tag. Consumers are parked behind tags that only a later-inserted trigger produces, which makes every issue cycle a fixed offset from the trigger's insertion. Overflow is provoked deliberately only in the scenario that checks R9.

// File: rtl/iq_pkg.sv
`timescale 1ns/1ps
package iq_pkg;
  typedef enum logic [1:0] {
    CLS_ALU  = 2'd0,
    CLS_MUL  = 2'd1,
    CLS_LOAD = 2'd2,
    CLS_ALT  = 2'd3
  } op_cls_e;

  localparam int unsigned BUS_PER_LANE = 3;
endpackage

// File: rtl/iq_entry.sv
`timescale 1ns/1ps
module iq_entry
  import iq_pkg::*;
#(
  parameter int unsigned TAG_W = 6,
  parameter int unsigned N_BUS = 6
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         ins_i,
  input  logic [TAG_W-1:0]             ins_dst_i,
  input  logic [TAG_W-1:0]             ins_src_l_i,
  input  logic                         ins_rdy_l_i,
  input  logic [TAG_W-1:0]             ins_src_r_i,
  input  logic                         ins_rdy_r_i,
  input  op_cls_e                      ins_cls_i,
  input  logic [N_BUS-1:0]             bus_vld_i,
  input  logic [N_BUS-1:0][TAG_W-1:0]  bus_tag_i,
  input  logic                         clr_i,
  output logic                         vld_o,
  output logic                         req_o,
  output logic [TAG_W-1:0]             dst_o,
  output op_cls_e                      cls_o
);
  logic             vld_q, rdy_l_q, rdy_r_q;
  logic [TAG_W-1:0] dst_q, src_l_q, src_r_q;
  op_cls_e          cls_q;
  logic             hit_l, hit_r, hit_l_new, hit_r_new;

  // compare held tags and incoming tags against every broadcast
  always_comb begin
    hit_l = 1'b0;
    hit_r = 1'b0;
    hit_l_new = 1'b0;
    hit_r_new = 1'b0;
    for (int b = 0; b < int'(N_BUS); b++) begin
      if (bus_vld_i[b]) begin
        if (bus_tag_i[b] == src_l_q)     hit_l = 1'b1;
        if (bus_tag_i[b] == src_r_q)     hit_r = 1'b1;
        if (bus_tag_i[b] == ins_src_l_i) hit_l_new = 1'b1;
        if (bus_tag_i[b] == ins_src_r_i) hit_r_new = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q   <= 1'b0;
      rdy_l_q <= 1'b0;
      rdy_r_q <= 1'b0;
      dst_q   <= '0;
      src_l_q <= '0;
      src_r_q <= '0;
      cls_q   <= CLS_ALU;
    end else if (ins_i) begin
      vld_q   <= 1'b1;
      dst_q   <= ins_dst_i;
      src_l_q <= ins_src_l_i;
      src_r_q <= ins_src_r_i;
      cls_q   <= ins_cls_i;
      rdy_l_q <= ins_rdy_l_i | hit_l_new;
      rdy_r_q <= ins_rdy_r_i | hit_r_new;
    end else if (vld_q) begin
      if (clr_i) vld_q <= 1'b0;
      rdy_l_q <= rdy_l_q | hit_l;
      rdy_r_q <= rdy_r_q | hit_r;
    end
  end

  assign vld_o = vld_q;
  assign req_o = vld_q & rdy_l_q & rdy_r_q;
  assign dst_o = dst_q;
  assign cls_o = cls_q;
endmodule

// File: rtl/iq_select.sv
`timescale 1ns/1ps
module iq_select #(
  parameter int unsigned N_ENT   = 8,
  parameter int unsigned ISSUE_W = 2
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [N_ENT-1:0]                req_i,
  input  logic [N_ENT-1:0]                ins_oh_i,
  output logic [ISSUE_W-1:0][N_ENT-1:0]   gnt_o,
  output logic [N_ENT-1:0]                gnt_any_o
);
  // older_q[j][i]: entry j was inserted before entry i
  logic [N_ENT-1:0][N_ENT-1:0] older_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      older_q <= '0;
    end else begin
      for (int i = 0; i < int'(N_ENT); i++) begin
        for (int j = 0; j < int'(N_ENT); j++) begin
          if (ins_oh_i[j] && i != j) older_q[i][j] <= 1'b1;
          else if (ins_oh_i[i])      older_q[i][j] <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    logic [N_ENT-1:0] avail;
    logic             win;
    avail = req_i;
    gnt_o = '0;
    for (int l = 0; l < int'(ISSUE_W); l++) begin
      for (int i = 0; i < int'(N_ENT); i++) begin
        win = avail[i];
        for (int j = 0; j < int'(N_ENT); j++) begin
          if (j != i && avail[j] && older_q[j][i]) win = 1'b0;
        end
        gnt_o[l][i] = win;
      end
      avail = avail & ~gnt_o[l];
    end
  end

  always_comb begin
    gnt_any_o = '0;
    for (int l = 0; l < int'(ISSUE_W); l++) gnt_any_o = gnt_any_o | gnt_o[l];
  end
endmodule

// File: rtl/iq_wake_line.sv
`timescale 1ns/1ps
module iq_wake_line #(
  parameter int unsigned TAG_W = 6,
  parameter int unsigned DEPTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [TAG_W-1:0] tag_i,
  output logic             vld_o,
  output logic [TAG_W-1:0] tag_o
);
  logic [DEPTH-1:0]            sr_vld;
  logic [DEPTH-1:0][TAG_W-1:0] sr_tag;

  for (genvar g = 0; g < int'(DEPTH); g++) begin : g_stage
    if (g == int'(DEPTH) - 1) begin : g_tail
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          sr_vld[g] <= 1'b0;
          sr_tag[g] <= '0;
        end else begin
          sr_vld[g] <= push_i;
          sr_tag[g] <= tag_i;
        end
      end
    end else begin : g_mid
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          sr_vld[g] <= 1'b0;
          sr_tag[g] <= '0;
        end else begin
          sr_vld[g] <= sr_vld[g+1];
          sr_tag[g] <= sr_tag[g+1];
        end
      end
    end
  end

  assign vld_o = sr_vld[0];
  assign tag_o = sr_tag[0];
endmodule

// File: rtl/iq_sched.sv
`timescale 1ns/1ps
module iq_sched
  import iq_pkg::*;
#(
  parameter int unsigned N_ENT        = 8,
  parameter int unsigned ISSUE_W      = 2,
  parameter int unsigned TAG_W        = 6,
  parameter int unsigned MUL_LAT      = 3,
  parameter int unsigned LOAD_HIT_LAT = 4,
  localparam int unsigned FU_W        = (ISSUE_W > 1) ? $clog2(ISSUE_W) : 1,
  localparam int unsigned N_BUS       = ISSUE_W * BUS_PER_LANE
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           ins_valid_i,
  input  logic [TAG_W-1:0]               ins_dst_i,
  input  logic [TAG_W-1:0]               ins_src_l_i,
  input  logic                           ins_rdy_l_i,
  input  logic [TAG_W-1:0]               ins_src_r_i,
  input  logic                           ins_rdy_r_i,
  input  logic [1:0]                     ins_cls_i,
  output logic                           full_o,
  output logic [ISSUE_W-1:0]             issue_valid_o,
  output logic [ISSUE_W-1:0][TAG_W-1:0]  issue_tag_o,
  output logic [ISSUE_W-1:0][FU_W-1:0]   issue_fu_o
);
  logic [N_ENT-1:0]                 vld_q;
  logic [N_ENT-1:0]                 req;
  logic [N_ENT-1:0]                 ins_oh;
  logic [N_ENT-1:0][TAG_W-1:0]      ent_dst;
  op_cls_e                          ent_cls [N_ENT];
  logic [ISSUE_W-1:0][N_ENT-1:0]    gnt;
  logic [N_ENT-1:0]                 gnt_any;
  logic [N_BUS-1:0]                 bus_vld;
  logic [N_BUS-1:0][TAG_W-1:0]      bus_tag;
  op_cls_e                          lane_cls [ISSUE_W];

  assign full_o = &vld_q;

  // lowest free slot takes the insert
  always_comb begin
    logic found;
    found  = 1'b0;
    ins_oh = '0;
    for (int i = 0; i < int'(N_ENT); i++) begin
      if (!vld_q[i] && !found) begin
        ins_oh[i] = ins_valid_i;
        found     = 1'b1;
      end
    end
  end

  for (genvar e = 0; e < int'(N_ENT); e++) begin : g_ent
    iq_entry #(.TAG_W(TAG_W), .N_BUS(N_BUS)) u_ent (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .ins_i       (ins_oh[e]),
      .ins_dst_i   (ins_dst_i),
      .ins_src_l_i (ins_src_l_i),
      .ins_rdy_l_i (ins_rdy_l_i),
      .ins_src_r_i (ins_src_r_i),
      .ins_rdy_r_i (ins_rdy_r_i),
      .ins_cls_i   (op_cls_e'(ins_cls_i)),
      .bus_vld_i   (bus_vld),
      .bus_tag_i   (bus_tag),
      .clr_i       (gnt_any[e]),
      .vld_o       (vld_q[e]),
      .req_o       (req[e]),
      .dst_o       (ent_dst[e]),
      .cls_o       (ent_cls[e])
    );
  end

  iq_select #(.N_ENT(N_ENT), .ISSUE_W(ISSUE_W)) u_sel (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req),
    .ins_oh_i  (ins_oh),
    .gnt_o     (gnt),
    .gnt_any_o (gnt_any)
  );

  for (genvar l = 0; l < int'(ISSUE_W); l++) begin : g_lane
    always_comb begin
      logic [1:0] cls_bits;
      issue_tag_o[l] = '0;
      cls_bits       = '0;
      for (int i = 0; i < int'(N_ENT); i++) begin
        if (gnt[l][i]) begin
          issue_tag_o[l] = issue_tag_o[l] | ent_dst[i];
          cls_bits       = cls_bits | ent_cls[i];
        end
      end
      lane_cls[l] = op_cls_e'(cls_bits);
    end

    assign issue_valid_o[l] = |gnt[l];
    assign issue_fu_o[l]    = FU_W'(l);

    // single-cycle classes wake in the issue cycle
    assign bus_vld[l*BUS_PER_LANE] = issue_valid_o[l] &&
                                     (lane_cls[l] == CLS_ALU || lane_cls[l] == CLS_ALT);
    assign bus_tag[l*BUS_PER_LANE] = issue_tag_o[l];

    iq_wake_line #(.TAG_W(TAG_W), .DEPTH(MUL_LAT - 1)) u_mul_line (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .push_i (issue_valid_o[l] && lane_cls[l] == CLS_MUL),
      .tag_i  (issue_tag_o[l]),
      .vld_o  (bus_vld[l*BUS_PER_LANE+1]),
      .tag_o  (bus_tag[l*BUS_PER_LANE+1])
    );

    iq_wake_line #(.TAG_W(TAG_W), .DEPTH(LOAD_HIT_LAT - 1)) u_ld_line (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .push_i (issue_valid_o[l] && lane_cls[l] == CLS_LOAD),
      .tag_i  (issue_tag_o[l]),
      .vld_o  (bus_vld[l*BUS_PER_LANE+2]),
      .tag_o  (bus_tag[l*BUS_PER_LANE+2])
    );
  end
endmodule

// File: rtl/iq_sched_chk.sv
`timescale 1ns/1ps
module iq_sched_chk #(
  parameter int unsigned N_ENT   = 8,
  parameter int unsigned ISSUE_W = 2
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          ins_valid_i,
  input logic                          full_i,
  input logic [ISSUE_W-1:0]            issue_valid_i,
  input logic [N_ENT-1:0]              vld_i,
  input logic [ISSUE_W-1:0][N_ENT-1:0] gnt_i,
  input logic [N_ENT-1:0]              gnt_any_i
);
  // R6
  lane_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !issue_valid_i[0] |-> issue_valid_i == '0);

  // R1
  grant_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_any_i & ~vld_i) == '0);

  // R9
  full_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_i && ins_valid_i) |=> (vld_i & ~$past(vld_i)) == '0);

  for (genvar l = 0; l < int'(ISSUE_W); l++) begin : g_lane
    // R6
    lane_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(gnt_i[l]));
    if (l > 0) begin : g_pair
      // R6
      lane_disjoint_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (gnt_i[l] & gnt_i[l-1]) == '0);
    end
  end

  for (genvar e = 0; e < int'(N_ENT); e++) begin : g_ent
    // R9
    slot_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      gnt_any_i[e] |=> !vld_i[e]);
  end
endmodule

bind iq_sched iq_sched_chk #(.N_ENT(N_ENT), .ISSUE_W(ISSUE_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .ins_valid_i   (ins_valid_i),
  .full_i        (full_o),
  .issue_valid_i (issue_valid_o),
  .vld_i         (vld_q),
  .gnt_i         (gnt),
  .gnt_any_i     (gnt_any)
);

// File: tb/sim_iq_sched.sv
`timescale 1ns/1ps
module sim_iq_sched;
  localparam int N_ENT = 8;
  localparam int ISSUE_W = 2;
  localparam int TAG_W = 6;
  localparam int MUL_LAT = 3;
  localparam int LD_LAT = 4;
  localparam int FU_W = 1;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ins_valid = 1'b0;
  logic [TAG_W-1:0] ins_dst = '0, ins_sl = '0, ins_sr = '0;
  logic ins_rl = 1'b0, ins_rr = 1'b0;
  logic [1:0] ins_cls = '0;
  logic full;
  logic [ISSUE_W-1:0] iss_vld;
  logic [ISSUE_W-1:0][TAG_W-1:0] iss_tag;
  logic [ISSUE_W-1:0][FU_W-1:0] iss_fu;

  iq_sched #(.N_ENT(N_ENT), .ISSUE_W(ISSUE_W), .TAG_W(TAG_W),
             .MUL_LAT(MUL_LAT), .LOAD_HIT_LAT(LD_LAT)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .ins_valid_i(ins_valid), .ins_dst_i(ins_dst),
    .ins_src_l_i(ins_sl), .ins_rdy_l_i(ins_rl), .ins_src_r_i(ins_sr),
    .ins_rdy_r_i(ins_rr), .ins_cls_i(ins_cls), .full_o(full),
    .issue_valid_o(iss_vld), .issue_tag_o(iss_tag), .issue_fu_o(iss_fu));

  always #10 clk = ~clk;  // 20 ns period

  int cyc = 0;
  int icyc [64];
  int ilane [64];
  int icnt [64];
  bit fullh [4096];
  int checks = 0, fails = 0;
  bit done = 1'b0;

  // sample mid-cycle, away from the rising edge
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (cyc < 4096) fullh[cyc] = full;
    for (int l = 0; l < ISSUE_W; l++) begin
      if (iss_vld[l]) begin
        icyc[iss_tag[l]] = cyc;
        ilane[iss_tag[l]] = int'(iss_fu[l]);
        icnt[iss_tag[l]] = icnt[iss_tag[l]] + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); #2;
    ins_valid = 1'b0;
    rst_ni = 1'b0;
    for (int t = 0; t < 64; t++) begin icyc[t] = -1; ilane[t] = -1; icnt[t] = 0; end
    @(negedge clk); #2;
    rst_ni = 1'b1;
  endtask

  task automatic ins(input int dst, input int sl, input bit rl, input int sr,
                     input bit rr, input int cls, output int at);
    @(negedge clk); #2;
    ins_valid = 1'b1;
    ins_dst = TAG_W'(dst);
    ins_sl = TAG_W'(sl); ins_rl = rl;
    ins_sr = TAG_W'(sr); ins_rr = rr;
    ins_cls = 2'(cls);
    at = cyc;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); #2;
      ins_valid = 1'b0;
    end
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int t, c8, tmp;
    // R10: reset state
    do_reset();
    idle(3);
    #1;
    chk(full == 1'b0, "R10 full", int'(full), 0);
    chk(iss_vld == '0, "R10 issue", int'(iss_vld), 0);

    // Scenario A: dependence tree, two lanes, single-cycle ops (R1 R2 R6 R8)
    ins(11, 10, 0, 10, 0, 0, tmp);   // both srcs on 10
    ins(12, 0, 1, 10, 0, 0, tmp);    // right src on 10
    ins(13, 10, 0, 0, 1, 0, tmp);
    ins(14, 11, 0, 12, 0, 0, tmp);
    ins(15, 13, 0, 14, 0, 0, tmp);
    ins(10, 0, 1, 0, 1, 0, t);       // trigger
    idle(12);
    chk(icyc[10] == t + 1, "R8 trigger issue", icyc[10] - t, 1);
    chk(icyc[11] == t + 2, "R2 level1 a", icyc[11] - t, 2);
    chk(icyc[12] == t + 2, "R1 right-src wake", icyc[12] - t, 2);
    chk(ilane[11] == 0, "R6 lane a", ilane[11], 0);
    chk(ilane[12] == 1, "R6 lane b", ilane[12], 1);
    chk(icyc[13] == t + 3, "R6 width limit defers", icyc[13] - t, 3);
    chk(icyc[14] == t + 3, "R2 level2", icyc[14] - t, 3);
    chk(ilane[13] == 0, "R6 oldest lane0", ilane[13], 0);
    chk(icyc[15] == t + 4, "R2 level3", icyc[15] - t, 4);
    chk(icnt[15] == 1, "R9 single issue", icnt[15], 1);

    // Scenario B: latency classes (R3 R4 R5)
    do_reset();
    ins(21, 20, 0, 0, 1, 0, tmp);
    ins(23, 0, 1, 22, 0, 0, tmp);
    ins(25, 24, 0, 0, 1, 0, tmp);
    ins(20, 0, 1, 0, 1, 1, tmp);
    ins(22, 0, 1, 0, 1, 2, tmp);
    ins(24, 0, 1, 0, 1, 3, tmp);
    idle(15);
    chk(icyc[21] - icyc[20] == MUL_LAT, "R3 mul distance", icyc[21] - icyc[20], MUL_LAT);
    chk(icyc[23] - icyc[22] == LD_LAT, "R4 load distance", icyc[23] - icyc[22], LD_LAT);
    chk(icyc[25] - icyc[24] == 1, "R5 class3 distance", icyc[25] - icyc[24], 1);

    // Scenario C: insert during broadcast (R7), missed broadcast (R1)
    do_reset();
    ins(30, 0, 1, 0, 1, 0, t);
    ins(31, 30, 0, 0, 1, 0, tmp);    // inserted in the cycle 30 is broadcast
    ins(32, 30, 0, 0, 1, 0, tmp);    // inserted after the broadcast
    idle(12);
    chk(icyc[30] == t + 1, "R8 ready at insert", icyc[30] - t, 1);
    chk(icyc[31] == t + 2, "R7 same-cycle capture", icyc[31] - t, 2);
    chk(icyc[32] == -1, "R1 no wake without tag", icyc[32], -1);

    // Scenario D: fill, drop while full, drain oldest-first (R9 R6)
    do_reset();
    for (int k = 0; k < 7; k++) ins(41 + k, 63, 0, 0, 1, 0, tmp);
    ins(63, 0, 1, 0, 1, 0, c8);
    ins(50, 0, 1, 0, 1, 0, tmp);     // offered while full
    idle(15);
    chk(fullh[c8] == 1'b0, "R9 not full at 7", int'(fullh[c8]), 0);
    chk(fullh[c8 + 1] == 1'b1, "R9 full at 8", int'(fullh[c8 + 1]), 1);
    chk(fullh[c8 + 2] == 1'b0, "R9 freed after grant", int'(fullh[c8 + 2]), 0);
    chk(icyc[63] == c8 + 1, "R2 trigger", icyc[63] - c8, 1);
    for (int k = 0; k < 7; k++) begin
      chk(icyc[41 + k] == c8 + 2 + k / 2, "R6 drain order", icyc[41 + k] - c8, 2 + k / 2);
      chk(ilane[41 + k] == k % 2, "R6 drain lane", ilane[41 + k], k % 2);
    end
    chk(icyc[50] == -1, "R9 dropped insert", icyc[50], -1);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule